// File: doc/BRIEF.md
# Blanking-Gated Video Memory Arbiter

This block owns a 2048-word by 32-bit video memory and splits its single port between two users: the graphics fetch engine and the processor bus. Ownership follows the video phase, not the requests. While the display is drawing, the graphics side has the port to itself. The processor can reach the memory only while the vertical blanking flag is high. A processor request made at any other time stays pending, with its ready signal held low, until blanking begins.

The processor sees the memory as an 8 KB window at byte address 0x2000_0000. The word address comes from byte address bits 12:2. Writes carry four byte-lane strobes, so a single byte or half-word can be updated. A zero strobe mask means a read. An access is taken on a clock edge where blanking is high. Ready then rises for exactly one cycle on the next cycle, with read data valid in that same cycle. This holds even if blanking has just ended. The graphics engine gets read data one cycle after it presents a word address, in every cycle in which no processor access is taken.

Top module: `vram_arbiter`

## Requirements
- R1: After synchronous reset, `cpu_ready` is low and stays low until an access is accepted.
- R2: While `vblank` is low, no processor access is accepted. A pending write leaves the memory unchanged, and `cpu_ready` stays low for as long as the request is held.
- R3: A pending request is accepted on the first rising clock edge at which `vblank` is high. `cpu_ready` is high in the following cycle.
- R4: A read (`cpu_wstrb` = 0) returns the addressed word on `cpu_rdata` in the same cycle that `cpu_ready` is high, one cycle after acceptance.
- R5: On a write, strobe bit k updates only byte k (data bits 8k+7:8k). Bytes whose strobe is 0 keep their old value.
- R6: A request whose address bits 31:13 differ from those of 0x2000_0000 is ignored: it never gets `cpu_ready` and writes nothing.
- R7: Each accepted access gives exactly one cycle of `cpu_ready`. A request held high after its ready is treated as a new access, so ready is never high in two consecutive cycles.
- R8: An access accepted on the last edge of blanking still completes, with `cpu_ready` and data in the next cycle even though `vblank` is then low.
- R9: In a cycle where no processor access is accepted, the memory reads `gfx_addr`, and `gfx_rdata` shows that word after the next edge.
- R10: The word address is byte address bits 12:2. Bits 1:0 have no effect on which word is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank | input | 1 | High during vertical blanking; processor access allowed |
| gfx_addr | input | 11 | Graphics fetch word address |
| gfx_rdata | output | 32 | Graphics read data, one cycle after address |
| cpu_valid | input | 1 | Processor request pending |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_wstrb | input | 4 | Byte write strobes; all zero means read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Processor read data, valid with `cpu_ready` |

## Verification
The hardest case to reach from the ports is the boundary between blanking and active video. One case is an access taken on the final blanking edge that must still finish after `vblank` falls. The other is a request that has been stalled for many cycles and must be taken on exactly the edge where `vblank` rises. The bench changes `vblank` on falling clock edges, one cycle after or one cycle before the request, and samples `cpu_ready` on each falling edge. This pins down the acceptance edge exactly. A full-memory fill and graphics sweep, followed by a pass over all sixteen strobe masks, checks the datapath against a shadow model kept in the bench.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    localparam int unsigned WORD_ADDR_W = 11;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned LANES       = DATA_W / 8;
    localparam logic [31:0] WIN_BASE    = 32'h2000_0000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } arb_state_e;

    // Lowest byte-address bit that lies above the window.
    function automatic int unsigned win_lsb(input int unsigned aw);
        return aw + 2;
    endfunction

endpackage

// File: rtl/vram_decode.sv
module vram_decode
    import vram_arb_pkg::*;
#(
    parameter int unsigned AW   = WORD_ADDR_W,
    parameter logic [31:0] BASE = WIN_BASE
) (
    input  logic [31:0]   cpu_addr,
    output logic          hit,
    output logic [AW-1:0] word
);
    localparam int unsigned TOP_LSB = win_lsb(AW);

    logic unused_byte_ofs;

    assign hit             = (cpu_addr[31:TOP_LSB] == BASE[31:TOP_LSB]);
    assign word            = cpu_addr[TOP_LSB-1:2];
    assign unused_byte_ofs = ^cpu_addr[1:0];

endmodule

// File: rtl/vram_ctrl.sv
module vram_ctrl
    import vram_arb_pkg::*;
#(
    parameter int unsigned NL = LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vblank,
    input  logic          cpu_valid,
    input  logic          cpu_hit,
    input  logic [NL-1:0] cpu_wstrb,
    output logic          accept,
    output logic [NL-1:0] lane_we,
    output logic          cpu_ready
);
    arb_state_e state_q, state_d;

    assign accept    = cpu_valid && cpu_hit && vblank && (state_q == ST_IDLE);
    assign lane_we   = accept ? cpu_wstrb : '0;
    assign cpu_ready = (state_q == ST_RESP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R3: a completion always traces back to a request taken during blanking
    p_ready_in_blank_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> $past(cpu_valid && vblank));

    // R6: only requests inside the window complete
    p_ready_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> $past(cpu_hit));

    // R7: ready is a single-cycle pulse
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R2: nothing starts during active video
    p_no_start_active_r2: assert property (@(posedge clk) disable iff (rst)
        !vblank |=> !cpu_ready);

endmodule

// File: rtl/vram_store.sv
module vram_store
    import vram_arb_pkg::*;
#(
    parameter int unsigned AW = WORD_ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic               clk,
    input  logic [AW-1:0]      addr,
    input  logic [DW/8-1:0]    lane_we,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata
);
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned NL    = DW / 8;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NL; k++) begin
            if (lane_we[k]) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vram_arb_pkg::*;
#(
    parameter int unsigned AW   = WORD_ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter logic [31:0] BASE = WIN_BASE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vblank,
    input  logic [AW-1:0]   gfx_addr,
    output logic [DW-1:0]   gfx_rdata,
    input  logic            cpu_valid,
    input  logic [31:0]     cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic [DW/8-1:0] cpu_wstrb,
    output logic            cpu_ready,
    output logic [DW-1:0]   cpu_rdata
);
    localparam int unsigned NL = DW / 8;

    logic          hit;
    logic [AW-1:0] cpu_word;
    logic          accept;
    logic [NL-1:0] lane_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_q;

    vram_decode #(.AW(AW), .BASE(BASE)) u_decode (
        .cpu_addr (cpu_addr),
        .hit      (hit),
        .word     (cpu_word)
    );

    vram_ctrl #(.NL(NL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .vblank    (vblank),
        .cpu_valid (cpu_valid),
        .cpu_hit   (hit),
        .cpu_wstrb (cpu_wstrb),
        .accept    (accept),
        .lane_we   (lane_we),
        .cpu_ready (cpu_ready)
    );

    // Port mux: the processor drives the memory only on its accept edge.
    assign mem_addr = accept ? cpu_word : gfx_addr;

    vram_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .addr    (mem_addr),
        .lane_we (lane_we),
        .wdata   (cpu_wdata),
        .rdata   (mem_q)
    );

    assign gfx_rdata = mem_q;
    assign cpu_rdata = mem_q;

    // R2: the memory is written only during blanking
    p_write_in_blank_r2: assert property (@(posedge clk) disable iff (rst)
        (lane_we != '0) |-> vblank);

endmodule

// File: tb/vram_arbiter_tb.sv
module vram_arbiter_tb;
    localparam int unsigned AW    = 11;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [31:0] BASE  = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vblank = 1'b0;
    logic [AW-1:0] gfx_addr = '0;
    logic [31:0] gfx_rdata;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_wstrb = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [DEPTH];

    always #4 clk = ~clk;

    vram_arbiter u_dut (
        .clk(clk), .rst(rst), .vblank(vblank),
        .gfx_addr(gfx_addr), .gfx_rdata(gfx_rdata),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wstrb(cpu_wstrb), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [31:0] pat(input int i);
        return (i * 32'h0100_0193) ^ 32'hA5C3_0F1E;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int k = 0; k < 4; k++) if (s[k]) r[8*k +: 8] = nw[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full access with vblank already high; returns data seen with ready.
    task automatic access(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic [31:0] rd, output bit got);
        got = 0; rd = '0;
        @(negedge clk);
        cpu_valid = 1; cpu_addr = a; cpu_wdata = d; cpu_wstrb = s;
        for (int c = 0; c < 8 && !got; c++) begin
            @(negedge clk);
            if (cpu_ready) begin got = 1; rd = cpu_rdata; end
        end
        cpu_valid = 0; cpu_wstrb = '0;
        if (got && s != 0) model[a[12:2]] = merge(model[a[12:2]], d, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit got;
        int bad;
        int seen;

        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'b0, cpu_ready}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, cpu_ready}, 32'd0);

        // Fill every word during blanking.
        vblank = 1;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 32'h0;
            access(BASE + 32'(i) * 4, pat(i), 4'hF, rd, got);
            if (!got) bad++;
        end
        chk("R3 fill completions", 32'(bad), 32'd0);

        // R9: graphics sweep during active video.
        @(negedge clk); vblank = 0;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            gfx_addr = AW'(i);
            @(negedge clk);
            if (gfx_rdata !== model[i]) bad++;
        end
        chk("R9 graphics sweep mismatches", 32'(bad), 32'd0);
        vblank = 1;

        // R4 / R10: CPU reads with every byte offset.
        for (int i = 0; i < 16; i++) begin
            int w = (i * 131) % DEPTH;
            access(BASE + 32'(w) * 4 + 32'(i % 4), 32'h0, 4'h0, rd, got);
            chk("R4 R10 read data", rd, model[w]);
        end

        // R5: all strobe masks on one word.
        for (int s = 0; s < 16; s++) begin
            logic [31:0] d = 32'h1111_1111 * 32'(s + 1);
            access(BASE + 32'd20 + 32'(s % 4), d, 4'(s), rd, got);
            access(BASE + 32'd20, 32'h0, 4'h0, rd, got);
            chk("R5 strobe merge", rd, model[5]);
        end

        // R6: out-of-window writes ignored.
        foreach (bad_addrs_dummy[j]) ;
        for (int j = 0; j < 2; j++) begin
            logic [31:0] a = (j == 0) ? 32'h2000_2010 : 32'h1000_0010;
            seen = 0;
            @(negedge clk);
            cpu_valid = 1; cpu_addr = a; cpu_wdata = 32'hDEAD_BEEF; cpu_wstrb = 4'hF;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (cpu_ready) seen++;
            end
            cpu_valid = 0; cpu_wstrb = 0;
            chk("R6 no ready out of window", 32'(seen), 32'd0);
            access(BASE + 32'h10, 32'h0, 4'h0, rd, got);
            chk("R6 aliased word unchanged", rd, model[4]);
        end

        // R2 then R3: stalled write, released by vblank rising.
        @(negedge clk); vblank = 0;
        cpu_valid = 1; cpu_addr = BASE + 32'h40; cpu_wdata = 32'h0BAD_F00D; cpu_wstrb = 4'hF;
        seen = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (cpu_ready) seen++;
        end
        chk("R2 stalled ready count", 32'(seen), 32'd0);
        vblank = 1;
        chk("R3 not ready before blank edge", {31'b0, cpu_ready}, 32'd0);
        @(negedge clk);
        chk("R3 ready after first blank edge", {31'b0, cpu_ready}, 32'd1);
        cpu_valid = 0; cpu_wstrb = 0;
        model[16] = 32'h0BAD_F00D;
        access(BASE + 32'h40, 32'h0, 4'h0, rd, got);
        chk("R3 stalled write landed", rd, 32'h0BAD_F00D);

        // R2: write abandoned during active video never lands.
        @(negedge clk); vblank = 0;
        cpu_valid = 1; cpu_addr = BASE + 32'h44; cpu_wdata = 32'hFFFF_0000; cpu_wstrb = 4'hF;
        repeat (5) @(negedge clk);
        cpu_valid = 0; cpu_wstrb = 0;
        vblank = 1;
        access(BASE + 32'h44, 32'h0, 4'h0, rd, got);
        chk("R2 abandoned write no effect", rd, model[17]);

        // R8: accepted on last blank edge, completes during active video.
        @(negedge clk);
        cpu_valid = 1; cpu_addr = BASE + 32'h84; cpu_wdata = 0; cpu_wstrb = 0;
        @(negedge clk);
        vblank = 0;
        chk("R8 ready after blank ends", {31'b0, cpu_ready}, 32'd1);
        chk("R8 data after blank ends", cpu_rdata, model[33]);
        @(negedge clk);
        chk("R8 no new access in active", {31'b0, cpu_ready}, 32'd0);
        cpu_valid = 0;
        repeat (3) @(negedge clk);
        vblank = 1;

        // R7: held request gives alternating single-cycle ready.
        @(negedge clk);
        cpu_valid = 1; cpu_addr = BASE + 32'h8; cpu_wstrb = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R7 ready pulse pattern", {31'b0, cpu_ready}, (c % 2 == 0) ? 32'd1 : 32'd0);
        end
        cpu_valid = 0;

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    int bad_addrs_dummy [1];

endmodule